// File: doc/BRIEF.md
# Command Stream Register-Write Decoder

This block sits behind a command fetch engine and turns a stream of 32-bit command words into single register writes on an internal register bus. The stream is cut into packets of five words. The first word of a packet is a header. The other four words are payloads. Each header byte holds a compact register index for one payload. Bit 7 of that index picks one of two register windows, and bits 6:0 pick a 32-bit register inside that window.

The decoder rebuilds the full 14-bit address for each payload and issues the writes in lane order. It drops writes to the filler register. It raises a single-cycle completion pulse when a write lands on the batch-end register. A packet that the upstream marks as finished too early is thrown away, and a sticky error flag records it.

The input side uses a valid/ready handshake with a last marker. The output is a registered write port with its own ready. Backpressure on that port is passed straight back to the input.

Top module: `cmd_regwr_decoder`

## Requirements
- R1: A packet is five accepted words: a header, then four payloads. After the fourth payload the next accepted word is taken as a new header.
- R2: Header bits 7:0 give the index for payload 1, bits 15:8 for payload 2, bits 23:16 for payload 3 and bits 31:24 for payload 4. The writes come out on the port in that payload order.
- R3: An index with bit 7 = 0 writes to address 0x1C00 + 4*index[6:0], which lies in the window 0x1C00..0x1DFF.
- R4: An index with bit 7 = 1 writes to address 0x2C00 + 4*index[6:0], which lies in the window 0x2C00..0x2DFF.
- R5: A payload whose index is 0x15 (address 0x1C54, the filler register) produces no write. Every other accepted payload produces exactly one write that carries its data unchanged. Index 0x95 is an ordinary write to 0x2C54.
- R6: `batchDone` is high for exactly one cycle: the cycle after a write to 0x1D00 (index 0x40) completes on the port. There is one pulse per such write, and no pulse for any other write.
- R7: While `wrEn` is high and `wrReady` is low, `wrAddr`, `wrData` and `wrEn` hold their values and `inReady` is low. A payload accepted at a clock edge shows up on the port from that edge until the cycle in which it completes.
- R8: When `inLast` is accepted on any word other than the fifth word of a packet, `truncErr` goes high and stays high until reset. The word that carries the marker is not written, and the next accepted word is a header.
- R9: When `inLast` is accepted on the fifth word of a packet, that word is decoded normally and `truncErr` does not change.
- R10: Synchronous reset (`rst` high at a clock edge) clears `wrEn`, `batchDone` and `truncErr`, sets `inReady` high, and makes the next accepted word a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inWord | input | 32 | Command word |
| inValid | input | 1 | Command word is present |
| inLast | input | 1 | Final word of the upstream transfer |
| inReady | output | 1 | Decoder takes the word at this edge |
| wrAddr | output | 14 | Register write address |
| wrData | output | 32 | Register write data |
| wrEn | output | 1 | Write request, held until taken |
| wrReady | input | 1 | Register bus takes the write |
| batchDone | output | 1 | One-cycle pulse after a batch-end write |
| truncErr | output | 1 | Sticky flag for a packet that ended early |

## Verification
The bench uses headers that mix both windows in all four lanes, so that a swapped byte lane or a misplaced bank bit sends a write to the wrong address or in the wrong order. It places the filler index in the middle lanes and compares it with its high-window twin 0x95. A design that tests only the low seven bits would drop the legitimate 0x2C54 write, and one that forwards the filler would show an extra bus cycle. Runs of consecutive batch-end writes check that each write produces its own pulse. An irregular `wrReady` pattern exposes any write that is lost or changed while it is stalled. Early-last cases (on the header and on a middle payload) are followed by a clean packet, so that a decoder that loses its alignment turns payloads into headers. Resetting in the middle of a packet checks that decoding starts again from a header.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = 4;
  localparam int IDX_W   = WORD_W / LANES;
  localparam int LANE_W  = $clog2(LANES);
  localparam int POS_W   = $clog2(LANES + 1);
  localparam int ADDR_W  = 14;

  localparam logic [ADDR_W-1:0] LOW_BASE  = 14'h1C00;
  localparam logic [ADDR_W-1:0] HIGH_BASE = 14'h2C00;
  localparam logic [IDX_W-2:0]  PAD_IDX   = 7'h15;
  localparam logic [ADDR_W-1:0] EXEC_ADDR = 14'h1D00;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic              capHdr;   // take the word as a header
    logic              loadData; // take the word as a payload
    logic              clrHdr;   // forget the captured header
    logic [LANE_W-1:0] lane;     // header byte that indexes this payload
  } ctrl_strobe_t;
endpackage

// File: rtl/cmd_dec_idxmap.sv
module cmd_dec_idxmap #(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 14,
  parameter logic [ADDR_W-1:0] LOW_BASE  = 14'h1C00,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 14'h2C00,
  parameter logic [IDX_W-2:0]  PAD_IDX   = 7'h15
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr,
  output logic              isPad
);
  localparam int OFS_W = IDX_W - 1 + 2;

  logic [OFS_W-1:0]  byteOfs;
  logic [ADDR_W-1:0] base;

  always_comb begin
    byteOfs = {idx[IDX_W-2:0], 2'b00};
    base    = idx[IDX_W-1] ? HIGH_BASE : LOW_BASE;
    addr    = base + ADDR_W'(byteOfs);
    // only the low window holds the filler register
    isPad   = !idx[IDX_W-1] && (idx[IDX_W-2:0] == PAD_IDX);
  end
endmodule

// File: rtl/cmd_dec_ctrl.sv
module cmd_dec_ctrl
  import cmd_dec_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         inLast,
  input  logic         wrBusy,
  input  logic         wrReady,
  output logic         inReady,
  output ctrl_strobe_t strobe,
  output logic         truncErr
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(LANES);

  logic [POS_W-1:0] pos;
  logic             accept;
  logic             atHeader;
  logic             atFinal;
  logic             early;

  always_comb begin
    inReady  = !(wrBusy && !wrReady);
    accept   = inValid && inReady;
    atHeader = (pos == '0);
    atFinal  = (pos == LAST_POS);
    early    = accept && inLast && !atFinal;

    strobe.capHdr   = accept && atHeader && !inLast;
    strobe.loadData = accept && !atHeader && (!inLast || atFinal);
    strobe.clrHdr   = early;
    strobe.lane     = LANE_W'(pos - POS_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= '0;
      truncErr <= 1'b0;
    end else begin
      if (accept) begin
        if (early || atFinal) pos <= '0;
        else                  pos <= pos + POS_W'(1);
      end
      if (early) truncErr <= 1'b1;
    end
  end
endmodule

// File: rtl/cmd_dec_path.sv
module cmd_dec_path
  import cmd_dec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] LOW_W  = LOW_BASE,
  parameter logic [ADDR_W-1:0] HIGH_W = HIGH_BASE,
  parameter logic [IDX_W-2:0]  PAD_I  = PAD_IDX,
  parameter logic [ADDR_W-1:0] EXEC_A = EXEC_ADDR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] inWord,
  input  ctrl_strobe_t      strobe,
  input  logic              wrReady,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic              batchDone
);
  logic [WORD_W-1:0] hdrReg;
  logic [IDX_W-1:0]  hdrByte [LANES];
  logic [IDX_W-1:0]  curIdx;
  logic [ADDR_W-1:0] curAddr;
  logic              curPad;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hdrByte[g] = hdrReg[g*IDX_W +: IDX_W];
  end

  assign curIdx = hdrByte[strobe.lane];

  cmd_dec_idxmap #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .LOW_BASE(LOW_W), .HIGH_BASE(HIGH_W), .PAD_IDX(PAD_I)
  ) u_map (
    .idx(curIdx), .addr(curAddr), .isPad(curPad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hdrReg    <= '0;
      wrEn      <= 1'b0;
      wrAddr    <= '0;
      wrData    <= '0;
      batchDone <= 1'b0;
    end else begin
      if (strobe.capHdr)      hdrReg <= inWord;
      else if (strobe.clrHdr) hdrReg <= '0;

      batchDone <= wrEn && wrReady && (wrAddr == EXEC_A);

      if (strobe.loadData && !curPad) begin
        wrEn   <= 1'b1;
        wrAddr <= curAddr;
        wrData <= inWord;
      end else if (wrReady) begin
        wrEn <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmd_regwr_decoder.sv
module cmd_regwr_decoder
  import cmd_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic              wrEn,
  input  logic              wrReady,
  output logic              batchDone,
  output logic              truncErr
);
  ctrl_strobe_t strobe;

  cmd_dec_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast),
    .wrBusy(wrEn), .wrReady(wrReady), .inReady(inReady),
    .strobe(strobe), .truncErr(truncErr)
  );

  cmd_dec_path u_path (
    .clk(clk), .rst(rst), .inWord(inWord), .strobe(strobe),
    .wrReady(wrReady), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .batchDone(batchDone)
  );
endmodule

// File: rtl/cmd_regwr_decoder_chk.sv
module cmd_regwr_decoder_chk
  import cmd_dec_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inReady,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [WORD_W-1:0] wrData,
  input logic              wrEn,
  input logic              wrReady,
  input logic              batchDone,
  input logic              truncErr
);
  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn && !wrReady |=> wrEn && $stable(wrAddr) && $stable(wrData));

  // R7
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn && !wrReady |-> !inReady);

  // R3 R4
  window_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> (wrAddr[13:9] == 5'b01110) || (wrAddr[13:9] == 5'b10110));

  // R5
  no_pad_write_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> wrAddr != 14'h1C54);

  // R6
  done_source_chk: assert property (@(posedge clk) disable iff (rst)
    batchDone |-> $past(wrEn && wrReady && (wrAddr == EXEC_ADDR)));

  // R8
  trunc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    truncErr |=> truncErr);
endmodule

bind cmd_regwr_decoder cmd_regwr_decoder_chk u_chk (
  .clk(clk), .rst(rst), .inReady(inReady), .wrAddr(wrAddr),
  .wrData(wrData), .wrEn(wrEn), .wrReady(wrReady),
  .batchDone(batchDone), .truncErr(truncErr)
);

// File: tb/tb_cmd_regwr_decoder.sv
module tb_cmd_regwr_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_N = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] inWord = '0;
  logic        inValid = 1'b0;
  logic        inLast = 1'b0;
  logic        inReady;
  logic [13:0] wrAddr;
  logic [31:0] wrData;
  logic        wrEn;
  logic        wrReady = 1'b1;
  logic        batchDone;
  logic        truncErr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [13:0] expAddr [LOG_N];
  logic [31:0] expData [LOG_N];
  logic [13:0] obsAddr [LOG_N];
  logic [31:0] obsData [LOG_N];
  int expN = 0;
  int obsN = 0;
  int doneCnt = 0;
  logic stallMode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic prevStall = 1'b0;
  logic [13:0] prevAddr = '0;
  logic [31:0] prevData = '0;

  cmd_regwr_decoder dut (
    .clk(clk), .rst(rst), .inWord(inWord), .inValid(inValid),
    .inLast(inLast), .inReady(inReady), .wrAddr(wrAddr), .wrData(wrData),
    .wrEn(wrEn), .wrReady(wrReady), .batchDone(batchDone), .truncErr(truncErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // irregular write-port acceptance, changed well after the edge
  always @(posedge clk) begin
    #2;
    if (stallMode) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wrReady = lfsr[0];
    end else begin
      wrReady = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor at the falling edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (prevStall) begin
        // R7: stalled write must hold
        check(wrEn === 1'b1 && wrAddr === prevAddr && wrData === prevData,
              "R7", "stalled write held", {18'd0, wrAddr}, {18'd0, prevAddr});
      end
      if (wrEn && !wrReady)
        check(inReady === 1'b0, "R7", "inReady during stall", 32'(inReady), 32'd0);
      prevStall = wrEn && !wrReady;
      prevAddr = wrAddr;
      prevData = wrData;
      if (wrEn && wrReady && obsN < LOG_N) begin
        obsAddr[obsN] = wrAddr;
        obsData[obsN] = wrData;
        obsN++;
      end
      if (batchDone) doneCnt++;
    end else begin
      prevStall = 1'b0;
    end
  end

  function automatic logic [13:0] mapIdx(input logic [7:0] idx);
    mapIdx = (idx[7] ? 14'h2C00 : 14'h1C00) + {5'd0, idx[6:0], 2'b00};
  endfunction

  task automatic clearLogs();
    expN = 0; obsN = 0; doneCnt = 0;
  endtask

  task automatic sendWord(input logic [31:0] w, input logic last);
    inWord = w; inLast = last; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  // full packet, expectation built from the index formulas
  task automatic sendPacket(input logic [31:0] hdr, input logic [31:0] d0,
                            input logic [31:0] d1, input logic [31:0] d2,
                            input logic [31:0] d3, input logic lastOnFinal);
    logic [31:0] d [4];
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    sendWord(hdr, 1'b0);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] idx;
      idx = hdr[k*8 +: 8];
      if (idx != 8'h15) begin
        expAddr[expN] = mapIdx(idx);
        expData[expN] = d[k];
        expN++;
      end
      sendWord(d[k], (k == 3) ? lastOnFinal : 1'b0);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic compareWrites(input string req);
    check(obsN == expN, req, "write count", 32'(obsN), 32'(expN));
    for (int i = 0; i < expN && i < obsN; i++) begin
      check(obsAddr[i] == expAddr[i], req, $sformatf("addr of write %0d", i),
            {18'd0, obsAddr[i]}, {18'd0, expAddr[i]});
      check(obsData[i] == expData[i], req, $sformatf("data of write %0d", i),
            obsData[i], expData[i]);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    settle(3);
    rst = 1'b0;
    settle(1);
  endtask

  task automatic testResetState();
    doReset();
    // R10
    check(inReady === 1'b1, "R10", "inReady after reset", 32'(inReady), 32'd1);
    check(wrEn === 1'b0, "R10", "wrEn after reset", 32'(wrEn), 32'd0);
    check(batchDone === 1'b0, "R10", "batchDone after reset", 32'(batchDone), 32'd0);
    check(truncErr === 1'b0, "R10", "truncErr after reset", 32'(truncErr), 32'd0);
  endtask

  task automatic testLowWindow();
    clearLogs();
    // R1 R2 R3: two packets back to back, lanes distinct
    sendPacket(32'h7F_03_22_01, 32'h1111_0001, 32'h2222_0002, 32'h3333_0003, 32'h4444_0004, 1'b0);
    sendPacket(32'h00_10_7E_05, 32'hA0A0_0000, 32'hB1B1_1111, 32'hC2C2_2222, 32'hD3D3_3333, 1'b0);
    settle(6);
    compareWrites("R2/R3");
  endtask

  task automatic testHighWindow();
    clearLogs();
    // R4: mixed banks across lanes
    sendPacket(32'h80_01_FF_81, 32'h0BAD_F00D, 32'hFEED_0001, 32'h1234_5678, 32'h8765_4321, 1'b0);
    settle(6);
    compareWrites("R4");
  endtask

  task automatic testPad();
    clearLogs();
    // R5: filler in the middle lanes, 0x95 is not filler
    sendPacket(32'h95_15_15_02, 32'hAAAA_0001, 32'hDEAD_0002, 32'hDEAD_0003, 32'hAAAA_0004, 1'b0);
    sendPacket(32'h15_15_15_15, 32'hDEAD_0005, 32'hDEAD_0006, 32'hDEAD_0007, 32'hDEAD_0008, 1'b0);
    settle(6);
    compareWrites("R5");
  endtask

  task automatic testDone();
    clearLogs();
    // R6: one lone batch-end write
    sendPacket(32'h03_02_40_01, 32'h1, 32'h2, 32'h3, 32'h4, 1'b0);
    settle(6);
    check(doneCnt == 1, "R6", "single batch-end pulse count", 32'(doneCnt), 32'd1);
    clearLogs();
    // R6: three batch-end writes, two of them consecutive
    sendPacket(32'h40_01_40_40, 32'h5, 32'h6, 32'h7, 32'h8, 1'b0);
    settle(6);
    check(doneCnt == 3, "R6", "repeated batch-end pulse count", 32'(doneCnt), 32'd3);
    compareWrites("R6");
    clearLogs();
    // R6: 0xC0 lands in the high window, no pulse
    sendPacket(32'hC0_C0_41_3F, 32'h9, 32'hA, 32'hB, 32'hC, 1'b0);
    settle(6);
    check(doneCnt == 0, "R6", "no pulse for other addresses", 32'(doneCnt), 32'd0);
  endtask

  task automatic testStall();
    clearLogs();
    stallMode = 1'b1;
    // R7: back-pressure on the write port, no loss or reordering
    sendPacket(32'h04_83_02_01, 32'hC0DE_0001, 32'hC0DE_0002, 32'hC0DE_0003, 32'hC0DE_0004, 1'b0);
    sendPacket(32'h40_15_90_7A, 32'hC0DE_0005, 32'hC0DE_0006, 32'hC0DE_0007, 32'hC0DE_0008, 1'b0);
    sendPacket(32'hA1_A2_A3_A4, 32'hC0DE_0009, 32'hC0DE_000A, 32'hC0DE_000B, 32'hC0DE_000C, 1'b0);
    settle(40);
    stallMode = 1'b0;
    settle(6);
    compareWrites("R7");
  endtask

  task automatic testTruncation();
    clearLogs();
    // R8: last on the second payload; first payload kept, second dropped
    sendWord(32'h00_00_02_01, 1'b0);
    expAddr[expN] = 14'h1C04; expData[expN] = 32'hE000_0001; expN++;
    sendWord(32'hE000_0001, 1'b0);
    sendWord(32'hE000_0002, 1'b1);
    settle(4);
    check(truncErr === 1'b1, "R8", "error after early last", 32'(truncErr), 32'd1);
    // R8: realigned on a header, error stays
    sendPacket(32'h08_07_06_05, 32'hF1, 32'hF2, 32'hF3, 32'hF4, 1'b0);
    settle(6);
    compareWrites("R8");
    check(truncErr === 1'b1, "R8", "error sticky", 32'(truncErr), 32'd1);
  endtask

  task automatic testResetMidPacket();
    doReset();
    check(truncErr === 1'b0, "R10", "reset clears error", 32'(truncErr), 32'd0);
    clearLogs();
    // R10: partial packet then reset; decoding restarts on a header
    sendWord(32'h0C_0B_0A_09, 1'b0);
    expAddr[expN] = 14'h1C24; expData[expN] = 32'h5151_0001; expN++;
    sendWord(32'h5151_0001, 1'b0);
    settle(4);
    doReset();
    sendPacket(32'h8C_8B_8A_89, 32'h61, 32'h62, 32'h63, 32'h64, 1'b0);
    settle(6);
    compareWrites("R10");
    check(truncErr === 1'b0, "R10", "no error after clean restart", 32'(truncErr), 32'd0);
    // R8: last on a header alone
    clearLogs();
    sendWord(32'h01_01_01_01, 1'b1);
    settle(4);
    check(truncErr === 1'b1, "R8", "error after last on header", 32'(truncErr), 32'd1);
    sendPacket(32'h11_12_13_14, 32'h71, 32'h72, 32'h73, 32'h74, 1'b0);
    settle(6);
    compareWrites("R8");
  endtask

  task automatic testLastOnFinal();
    doReset();
    clearLogs();
    // R9: last on the fifth word is normal
    sendPacket(32'h33_B3_40_01, 32'h81, 32'h82, 32'h83, 32'h84, 1'b1);
    sendPacket(32'h02_03_04_05, 32'h91, 32'h92, 32'h93, 32'h94, 1'b1);
    settle(6);
    compareWrites("R9");
    check(truncErr === 1'b0, "R9", "no error on final last", 32'(truncErr), 32'd0);
    check(doneCnt == 1, "R9", "batch-end in last packet", 32'(doneCnt), 32'd1);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        testResetState();
        testLowWindow();
        testHighWindow();
        testPad();
        testDone();
        testStall();
        testTruncation();
        testResetMidPacket();
        testLastOnFinal();
      end
      begin
        while (cycles < 100000) @(negedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule